// File: doc/BRIEF.md
# Per-Slave Bus Arbiter with Selectable Fixed or Rotating Priority

This block decides which of several bus masters owns one slave port of a crossbar. Each slave gets its own instance, and a mode input chooses the policy for that slave. In fixed mode, a packed priority word gives each master a 4-bit level, and the lowest level value wins. In rotating mode, masters are served in turn, starting from port order after reset and resuming just past the last master served.

The arbiter is a two-state machine. In `ARB_IDLE` no grant is driven and the request lines are examined every cycle. The `claim` transition moves to `ARB_OWNED` when any request is present. In `ARB_OWNED` the grant is frozen along the `hold` transition until the owner signals the end of its transfer on `xfer_done`. At that boundary the `handover` transition re-arbitrates straight into a new grant when requests are pending. The `release` transition goes back to `ARB_IDLE` when no request is pending. The mode and the priority word are read only at these arbitration points. The grant leaves a register one clock after the arbitration cycle. `grant_idx` reads 0 whenever no grant is driven.

Top module: `slave_arbiter`

## Requirements
- R1: While reset is held low and just after it is released, `grant` is all zeros and `grant_idx` is 0, and the rotating search starts at master 0.
- R2: When no master requests at an arbitration point, `grant` is zero in the next cycle, and `xfer_done` pulses while idle have no effect.
- R3: `grant` has at most one bit set, and when a bit is set, `grant_idx` gives its position.
- R4: Once granted, `grant` and `grant_idx` stay unchanged until `xfer_done` is high, even if the requests change or the owner drops its request.
- R5: With `mode_rr` = 0, the requester whose level field (bits [4i+3:4i] of `prio_word` for master i) holds the smallest value is granted.
- R6: With `mode_rr` = 0 and two requesters sharing the smallest level, the lower master index is granted.
- R7: With `mode_rr` = 0, a top-level master that keeps requesting wins every arbitration, and lower-level masters starve.
- R8: With `mode_rr` = 1 after reset and all masters requesting with `xfer_done` held high, grants go 0, 1, 2, … N-1, then wrap to 0.
- R9: With `mode_rr` = 1, the search after a grant to master k starts at k+1 (wrapping to 0). Idle periods and fixed-mode grants leave this start point unchanged.
- R10: `mode_rr` is sampled at each arbitration point, so switching it between transfers changes the policy of the next grant.
- R11: When `xfer_done` is high and requests are pending, the next grant appears in the following cycle with no idle cycle in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | NUM_MASTERS | Request line for each master |
| mode_rr | input | 1 | 1 = rotating priority, 0 = fixed priority |
| prio_word | input | NUM_MASTERS*LVL_W | Packed level per master; a lower value means higher priority |
| xfer_done | input | 1 | Current owner's transfer completes this cycle |
| grant | output | NUM_MASTERS | One-hot grant |
| grant_idx | output | IDX_W | Index of the granted master (0 when none) |

## Verification
The hardest condition to reach is a rotating search whose start point was set many transfers earlier: the start point must survive idle gaps and fixed-mode grants. The stimulus does this with scripted sequences. It grants a master in rotating mode, releases it, idles, and serves a fixed-mode grant. It then returns to rotating mode with two candidates whose order shows the stored start point. A separate sequence holds `xfer_done` high with all masters requesting, which walks the full wrap-around.

// File: rtl/slv_arb_pkg.sv
package slv_arb_pkg;

    typedef enum logic [0:0] {
        ARB_IDLE  = 1'b0,
        ARB_OWNED = 1'b1
    } arb_state_e;

    // Successor of a master index with wrap-around at n.
    function automatic int unsigned wrap_next(input int unsigned idx, input int unsigned n);
        return (idx + 1 >= n) ? 0 : idx + 1;
    endfunction

endpackage

// File: rtl/slv_arb_fixed_pick.sv
module slv_arb_fixed_pick #(
    parameter int NUM_MASTERS = 8,
    parameter int LVL_W       = 4,
    localparam int IDX_W      = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1
) (
    input  logic [NUM_MASTERS-1:0]       req,
    input  logic [NUM_MASTERS*LVL_W-1:0] prio,
    output logic [IDX_W-1:0]             win
);

    logic [LVL_W-1:0] best;
    logic             found;

    // Ascending scan with strict compare: equal levels keep the lower index.
    always_comb begin
        win   = '0;
        best  = '1;
        found = 1'b0;
        for (int i = 0; i < NUM_MASTERS; i++) begin
            if (req[i] && (!found || (prio[i*LVL_W +: LVL_W] < best))) begin
                found = 1'b1;
                best  = prio[i*LVL_W +: LVL_W];
                win   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/slv_arb_rr_pick.sv
module slv_arb_rr_pick #(
    parameter int NUM_MASTERS = 8,
    localparam int IDX_W      = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1
) (
    input  logic [NUM_MASTERS-1:0] req,
    input  logic [IDX_W-1:0]       start,
    output logic [IDX_W-1:0]       win
);

    logic found;
    int   pos;

    // First requester found walking upward from start, wrapping at NUM_MASTERS.
    always_comb begin
        win   = '0;
        found = 1'b0;
        pos   = 0;
        for (int k = 0; k < NUM_MASTERS; k++) begin
            pos = int'(start) + k;
            if (pos >= NUM_MASTERS) pos = pos - NUM_MASTERS;
            if (!found && req[pos[IDX_W-1:0]]) begin
                found = 1'b1;
                win   = pos[IDX_W-1:0];
            end
        end
    end

endmodule

// File: rtl/slave_arbiter.sv
module slave_arbiter #(
    parameter int NUM_MASTERS = 8,
    parameter int LVL_W       = 4,
    localparam int IDX_W      = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_MASTERS-1:0]       req,
    input  logic                         mode_rr,
    input  logic [NUM_MASTERS*LVL_W-1:0] prio_word,
    input  logic                         xfer_done,
    output logic [NUM_MASTERS-1:0]       grant,
    output logic [IDX_W-1:0]             grant_idx
);
    import slv_arb_pkg::*;

    arb_state_e       state_q, state_d;
    logic [IDX_W-1:0] rr_ptr_q;
    logic [IDX_W-1:0] fx_win, rr_win, sel_idx;
    logic             any_req;
    logic             arb_point;

    slv_arb_fixed_pick #(.NUM_MASTERS(NUM_MASTERS), .LVL_W(LVL_W)) fixed_i (
        .req  (req),
        .prio (prio_word),
        .win  (fx_win)
    );

    slv_arb_rr_pick #(.NUM_MASTERS(NUM_MASTERS)) rr_i (
        .req   (req),
        .start (rr_ptr_q),
        .win   (rr_win)
    );

    assign any_req   = |req;
    assign sel_idx   = mode_rr ? rr_win : fx_win;
    assign arb_point = (state_q == ARB_IDLE) || xfer_done;

    // Transitions: claim, hold, handover, release.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ARB_IDLE:  if (any_req) state_d = ARB_OWNED;              // claim
            ARB_OWNED: if (xfer_done) begin
                           state_d = any_req ? ARB_OWNED : ARB_IDLE;  // handover / release
                       end                                            // else hold
            default:   state_d = ARB_IDLE;
        endcase
    end

    // State register and rotation pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ARB_IDLE;
            rr_ptr_q <= '0;
        end else begin
            state_q <= state_d;
            if (arb_point && any_req && mode_rr)
                rr_ptr_q <= IDX_W'(wrap_next(int'(rr_win), NUM_MASTERS));
        end
    end

    // Registered outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant     <= '0;
            grant_idx <= '0;
        end else if (arb_point) begin
            if (any_req) begin
                grant     <= NUM_MASTERS'(1) << sel_idx;
                grant_idx <= sel_idx;
            end else begin
                grant     <= '0;
                grant_idx <= '0;
            end
        end
    end

    // ---------------- assertions ----------------
    p_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    p_idx_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (grant != '0) |-> grant[grant_idx]);

    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ARB_OWNED && !xfer_done) |=> ($stable(grant) && $stable(grant_idx)));

    p_no_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_point && !any_req) |=> (grant == '0));

    p_granted_requester_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_point && any_req) |-> req[sel_idx]);

    p_ptr_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_point && any_req && mode_rr)
        |=> (rr_ptr_q == IDX_W'(wrap_next(int'(grant_idx), NUM_MASTERS))));

    p_ptr_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(arb_point && any_req && mode_rr) |=> $stable(rr_ptr_q));

endmodule

// File: tb/slave_arbiter_tb.sv
module slave_arbiter_tb_top;

    localparam int N  = 8;
    localparam int LW = 4;
    localparam int IW = 3;
    localparam logic [N*LW-1:0] PRIO_DEF = 32'h6543_0210;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [N-1:0]  req;
    logic          mode_rr;
    logic [N*LW-1:0] prio_word;
    logic          xfer_done;
    logic [N-1:0]  grant;
    logic [IW-1:0] grant_idx;

    int n_cmp = 0;
    int n_err = 0;

    always #5 clk = ~clk;

    slave_arbiter #(.NUM_MASTERS(N), .LVL_W(LW)) dut_i (
        .clk(clk), .rst_n(rst_n), .req(req), .mode_rr(mode_rr),
        .prio_word(prio_word), .xfer_done(xfer_done),
        .grant(grant), .grant_idx(grant_idx)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // exp < 0 means no grant expected.
    task automatic chk(input string r, input int exp);
        logic [N-1:0]  eg;
        logic [IW-1:0] ei;
        eg = (exp < 0) ? '0 : (N'(1) << exp);
        ei = (exp < 0) ? '0 : IW'(exp);
        n_cmp++;
        if (grant !== eg || grant_idx !== ei) begin
            n_err++;
            $display("FAIL %s: grant=%b idx=%0d expected grant=%b idx=%0d",
                     r, grant, grant_idx, eg, ei);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; req = '0; xfer_done = 1'b0;
        repeat (2) tick();
        rst_n = 1'b1;
    endtask

    // From idle: request, expect a grant, then release to idle.
    task automatic grant_once(input string r, input logic [N-1:0] rq, input int exp);
        req = rq; tick();
        chk(r, exp);
        req = '0; xfer_done = 1'b1; tick();
        xfer_done = 1'b0;
        chk("R2 release", -1);
    endtask

    task automatic t_reset_r1();
        mode_rr = 1'b0; prio_word = PRIO_DEF;
        rst_n = 1'b0; req = 8'hFF; xfer_done = 1'b0;
        repeat (2) tick();
        chk("R1 in reset", -1);
        req = '0; rst_n = 1'b1; tick();
        chk("R1 after reset", -1);
        mode_rr = 1'b1; req = 8'h81; tick();
        chk("R1 rotation starts at 0", 0);
        req = '0; xfer_done = 1'b1; tick(); xfer_done = 1'b0;
    endtask

    task automatic t_idle_r2();
        do_reset();
        req = '0;
        xfer_done = 1'b1; tick(); chk("R2 done while idle", -1);
        xfer_done = 1'b0; tick(); chk("R2 idle", -1);
    endtask

    task automatic t_fixed_r5_r6();
        do_reset();
        mode_rr = 1'b0; prio_word = PRIO_DEF;
        grant_once("R5 upper masters", 8'hF0, 4);
        grant_once("R5 level 0 beats 2", 8'h0C, 3);
        grant_once("R6 tie lower index", 8'h09, 0);
        prio_word = 32'h0123_4567;
        grant_once("R5 reversed levels", 8'hFF, 7);
        grant_once("R5 reversed subset", 8'h16, 4);
        prio_word = PRIO_DEF;
    endtask

    task automatic t_hold_r4();
        do_reset();
        mode_rr = 1'b0;
        req = 8'h10; tick(); chk("R4 initial", 4);
        req = 8'h01; tick(); chk("R4 held vs better req", 4);
        req = 8'h00; tick(); chk("R4 held after owner drops", 4);
        req = 8'h01; xfer_done = 1'b1; tick(); xfer_done = 1'b0;
        chk("R11 handover", 0);
        req = '0; xfer_done = 1'b1; tick(); xfer_done = 1'b0;
        chk("R2 release", -1);
    endtask

    task automatic t_starve_r7();
        do_reset();
        mode_rr = 1'b0;
        req = 8'h21; tick(); chk("R7 first", 0);
        xfer_done = 1'b1;
        for (int k = 0; k < 3; k++) begin
            tick(); chk("R7 high level keeps winning", 0);
        end
        req = 8'h20; tick(); chk("R11 low level after top stops", 5);
        req = '0; tick(); xfer_done = 1'b0;
        chk("R2 release", -1);
    endtask

    task automatic t_rr_walk_r8();
        do_reset();
        mode_rr = 1'b1;
        req = 8'hFF; tick(); chk("R8 first", 0);
        xfer_done = 1'b1;
        for (int k = 1; k <= N; k++) begin
            tick(); chk("R8 rotation", k % N);
        end
        req = '0; tick(); xfer_done = 1'b0;
        chk("R2 release", -1);
    endtask

    task automatic t_rr_ptr_r9();
        do_reset();
        mode_rr = 1'b1;
        req = 8'h24; tick(); chk("R9 first", 2);
        xfer_done = 1'b1;
        tick(); chk("R9 after 2", 5);
        tick(); chk("R9 wrap", 2);
        req = '0; tick(); xfer_done = 1'b0;
        chk("R2 release", -1);
        repeat (4) tick();
        grant_once("R9 pointer kept over idle", 8'h24, 5);
    endtask

    task automatic t_mode_r10();
        do_reset();
        mode_rr = 1'b1; prio_word = PRIO_DEF;
        grant_once("R10 rotating", 8'h03, 0);
        mode_rr = 1'b0;
        grant_once("R10 fixed", 8'h82, 1);
        mode_rr = 1'b1;
        grant_once("R10 rotating resumes", 8'h03, 1);
    endtask

    initial begin
        #(200000 * 10);
        n_err++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
        $finish;
    end

    initial begin
        t_reset_r1();
        t_idle_r2();
        t_fixed_r5_r6();
        t_hold_r4();
        t_starve_r7();
        t_rr_walk_r8();
        t_rr_ptr_r9();
        t_mode_r10();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
        $finish;
    end

endmodule